// File: doc/BRIEF.md
# Serial-bus wiper register slave

This block is a two-wire serial bus slave that holds three 8-bit wiper positions for a set of digital potentiometers. Each wiper has a working register, whose value sets the tap, and a nonvolatile shadow copy, modelled here as plain flip-flops. A master reaches the block through a fixed 7-bit device address. The first byte after the address is an instruction byte. It names one of the three wipers and says whether a write should also reach the shadow copy.

A write sends the write address, the instruction byte and a data byte. The data byte replaces the selected working register in full. A read first sets the wiper pointer with a dummy write of address plus instruction byte. The master then issues a repeated START with the read address, and the block returns the selected working register. SCL and SDA are oversampled by the system clock through two-stage synchronisers. The block pulls SDA low through an output enable that feeds an external open-drain pad.

Top module: `i2c_wiper_slave`

## Requirements
- R1: After reset every working register and every shadow register reads 00h, and SDA is released (`sda_oe` = 0).
- R2: An address byte whose upper seven bits equal 1010111 is acknowledged; bit 0 is R/W (0 write, 1 read). Any other address is not acknowledged, and the block ignores the bus until the next START.
- R3: An instruction byte is acknowledged when bits 6:2 are zero and the selector in bits 1:0 is 00, 01 or 10 (wipers 0, 1, 2); bit 7 is the store flag.
- R4: An instruction byte with selector 11 is not acknowledged, and no register changes.
- R5: An instruction byte with any of bits 6:2 set is not acknowledged, and no register changes.
- R6: After a valid instruction, the data byte is acknowledged and its full 8 bits replace the selected working register when the acknowledge is driven. Other wipers keep their values.
- R7: With store flag 1, the data byte is also copied into the selected shadow register. With store flag 0, the shadow registers keep their values.
- R8: A dummy write of address and instruction byte sets the read pointer without changing any register, whatever the store flag. A repeated START with address 10101111 is acknowledged, and the block then sends the selected working register MSB first.
- R9: SDA is changed only while SCL is low. SDA is released after each acknowledge clock, after the eighth read bit and on STOP.
- R10: A START at any point restarts the address phase. Bytes sent after a not-acknowledged byte without a new START are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock as seen on the pad |
| sda_i | input | 1 | Bus data as seen on the pad |
| sda_oe | output | 1 | 1 pulls SDA low |
| wiper_o | output | 24 | Working registers, wiper n at bits 8n+7:8n |
| nvm_o | output | 24 | Shadow registers, wiper n at bits 8n+7:8n |

## Verification
The bench writes every wiper with both store-flag values and with all-ones, all-zero and mixed data. After each write it checks the registers at the ports and reads the wiper back over the bus. A design that mixed up the selector, loaded only some bits or always copied into the shadow would fail these checks. The bench sweeps every foreign device address and every middle bit of the instruction byte, and it sends the reserved selector. A slave that acknowledged any of these, or updated a register afterwards, would be reported. A restart in the middle of a write and a read set up with the store flag set check that the pointer follows the latest instruction and that a read never stores anything.

// File: rtl/i2c_wiper_slave.sv
module i2c_wiper_slave #(
  parameter logic [6:0] DEV_ADDR = 7'b1010111,
  parameter int         WIDTH    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 scl_i,
  input  logic                 sda_i,
  output logic                 sda_oe,
  output logic [3*WIDTH-1:0]   wiper_o,
  output logic [3*WIDTH-1:0]   nvm_o
);
  localparam int NW = 3;

  typedef enum logic [1:0] {S_IDLE, S_RX, S_ACK, S_TX} st_t;
  typedef enum logic [1:0] {K_ADDR, K_INSTR, K_DATA} kind_t;

  logic [1:0] scl_sy, sda_sy;
  logic       scl_d, sda_d;
  st_t        st;
  kind_t      kind;
  logic [2:0] cnt;
  logic       got8, rd, wt;
  logic [1:0] ptr;
  logic [WIDTH-1:0] sh;
  logic [WIDTH-1:0] wip [NW];
  logic [WIDTH-1:0] nv  [NW];
  logic [WIDTH-1:0] rd_val;

  wire scl_s     = scl_sy[1];
  wire sda_s     = sda_sy[1];
  wire scl_rise  = scl_s & ~scl_d;
  wire scl_fall  = ~scl_s & scl_d;
  wire start_det = scl_s & scl_d & sda_d & ~sda_s;
  wire stop_det  = scl_s & scl_d & ~sda_d & sda_s;
  wire is_idle   = (st == S_IDLE);

  wire addr_ok  = (sh[WIDTH-1:1] == DEV_ADDR);
  wire instr_ok = (sh[WIDTH-2:2] == '0) && (sh[1:0] != 2'b11);

  assign rd_val = (ptr == 2'd2) ? wip[2] : (ptr == 2'd1) ? wip[1] : wip[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_d  <= scl_s;
      sda_d  <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      kind   <= K_ADDR;
      cnt    <= '0;
      got8   <= 1'b0;
      rd     <= 1'b0;
      wt     <= 1'b0;
      ptr    <= '0;
      sh     <= '0;
      sda_oe <= 1'b0;
      for (int i = 0; i < NW; i++) begin
        wip[i] <= '0;
        nv[i]  <= '0;
      end
    end else if (start_det) begin
      st     <= S_RX;
      kind   <= K_ADDR;
      cnt    <= '0;
      got8   <= 1'b0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      st     <= S_IDLE;
      got8   <= 1'b0;
      sda_oe <= 1'b0;
    end else begin
      case (st)
        S_RX: begin
          if (scl_rise) begin
            sh  <= {sh[WIDTH-2:0], sda_s};
            cnt <= cnt + 3'd1;
            if (cnt == 3'd7) got8 <= 1'b1;
          end else if (scl_fall && got8) begin
            got8 <= 1'b0;
            case (kind)
              K_ADDR: begin
                if (addr_ok) begin
                  sda_oe <= 1'b1;
                  rd     <= sh[0];
                  st     <= S_ACK;
                end else begin
                  st <= S_IDLE;
                end
              end
              K_INSTR: begin
                if (instr_ok) begin
                  sda_oe <= 1'b1;
                  ptr    <= sh[1:0];
                  wt     <= sh[WIDTH-1];
                  st     <= S_ACK;
                end else begin
                  st <= S_IDLE;
                end
              end
              default: begin
                sda_oe <= 1'b1;
                st     <= S_ACK;
                for (int i = 0; i < NW; i++) begin
                  if (ptr == 2'(i)) begin
                    wip[i] <= sh;
                    if (wt) nv[i] <= sh;
                  end
                end
              end
            endcase
          end
        end
        S_ACK: begin
          if (scl_fall) begin
            sda_oe <= 1'b0;
            cnt    <= '0;
            case (kind)
              K_ADDR: begin
                if (rd) begin
                  st     <= S_TX;
                  sh     <= rd_val;
                  sda_oe <= ~rd_val[WIDTH-1];
                end else begin
                  kind <= K_INSTR;
                  st   <= S_RX;
                end
              end
              K_INSTR: begin
                kind <= K_DATA;
                st   <= S_RX;
              end
              default: st <= S_IDLE;
            endcase
          end
        end
        S_TX: begin
          if (scl_fall) begin
            if (cnt == 3'd7) begin
              sda_oe <= 1'b0;
              st     <= S_IDLE;
            end else begin
              cnt    <= cnt + 3'd1;
              sh     <= {sh[WIDTH-2:0], 1'b0};
              sda_oe <= ~sh[WIDTH-2];
            end
          end
        end
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < NW; g++) begin : g_out
    assign wiper_o[g*WIDTH +: WIDTH] = wip[g];
    assign nvm_o[g*WIDTH +: WIDTH]   = nv[g];
  end
endmodule

// File: rtl/i2c_wiper_slave_chk.sv
module i2c_wiper_slave_chk #(
  parameter int WIDTH = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               scl_s,
  input logic               scl_fall,
  input logic               stop_det,
  input logic               is_idle,
  input logic               sda_oe,
  input logic [3*WIDTH-1:0] wiper_o,
  input logic [3*WIDTH-1:0] nvm_o
);
  AST_SDA_HELD_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s)) |-> $stable(sda_oe)) else $error("sda moved while scl high"); // R9

  AST_RELEASE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stop_det) |-> !sda_oe) else $error("sda held after stop"); // R9

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    is_idle |-> !sda_oe) else $error("sda driven while idle"); // R10

  AST_WIPER_AT_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wiper_o) |-> ($past(scl_fall) && sda_oe)) else $error("wiper moved off ack"); // R6

  AST_SHADOW_AT_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(nvm_o) |-> ($past(scl_fall) && sda_oe)) else $error("shadow moved off ack"); // R7
endmodule

bind i2c_wiper_slave i2c_wiper_slave_chk #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_s    (scl_s),
  .scl_fall (scl_fall),
  .stop_det (stop_det),
  .is_idle  (is_idle),
  .sda_oe   (sda_oe),
  .wiper_o  (wiper_o),
  .nvm_o    (nvm_o)
);

// File: tb/i2c_wiper_slave_tb.sv
module i2c_wiper_slave_tb;
  localparam int CLK_P = 10;
  localparam int Q     = 6;
  localparam logic [7:0] AW = 8'hAE;
  localparam logic [7:0] AR = 8'hAF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic [23:0] wiper_o, nvm_o;
  wire sda_line = sda_m & ~sda_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] ew [3];
  logic [7:0] en [3];

  always #(CLK_P/2) clk = ~clk;

  i2c_wiper_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .wiper_o(wiper_o), .nvm_o(nvm_o)
  );

  task automatic chk(input bit ok, input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic xbit(input logic b, output logic r);
    sda_m = b; wq();
    scl_m = 1'b1; wq();
    r = sda_line; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic bstart();
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b0; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic bstop();
    sda_m = 1'b0; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b1; wq();
  endtask

  task automatic sbyte(input logic [7:0] b, output logic nack);
    logic r;
    for (int i = 7; i >= 0; i--) xbit(b[i], r);
    xbit(1'b1, nack);
  endtask

  task automatic rbyte(output logic [7:0] v);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      xbit(1'b1, r);
      v[i] = r;
    end
    xbit(1'b1, r);
  endtask

  function automatic logic [23:0] pk(input logic [7:0] a [3]);
    return {a[2], a[1], a[0]};
  endfunction

  task automatic wr(input logic [7:0] ins, input logic [7:0] d, output logic n0, output logic n1, output logic n2);
    bstart();
    sbyte(AW, n0);
    sbyte(ins, n1);
    sbyte(d, n2);
    bstop();
  endtask

  task automatic rdw(input logic [7:0] ins, output logic [7:0] v, output logic n0, output logic n1, output logic n2);
    bstart();
    sbyte(AW, n0);
    sbyte(ins, n1);
    bstart();
    sbyte(AR, n2);
    rbyte(v);
    bstop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic n0, n1, n2, n3;
    logic [7:0] v, d;
    for (int k = 0; k < 3; k++) begin ew[k] = 8'h00; en[k] = 8'h00; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(wiper_o == 24'h0, "R1 wipers", wiper_o, 24'h0);
    chk(nvm_o == 24'h0, "R1 shadows", nvm_o, 24'h0);
    chk(sda_oe == 1'b0, "R1 sda", {23'h0, sda_oe}, 24'h0);

    // R6 R7 R8 sweep over wipers, store flag and data
    for (int k = 0; k < 3; k++) begin
      for (int w = 0; w < 2; w++) begin
        for (int i = 0; i < 6; i++) begin
          d = (i == 0) ? 8'hFF : (i == 1) ? 8'h00 : 8'((k * 83 + i * 59 + w * 29 + 7) & 255);
          wr({w[0], 5'b0, k[1:0]}, d, n0, n1, n2);
          ew[k] = d;
          if (w == 1) en[k] = d;
          chk({n0, n1, n2} == 3'b000, "R2 R3 R6 acks", {21'h0, n0, n1, n2}, 24'h0);
          chk(wiper_o == pk(ew), "R6 wiper", wiper_o, pk(ew));
          chk(nvm_o == pk(en), "R7 shadow", nvm_o, pk(en));
          rdw({~w[0], 5'b0, k[1:0]}, v, n0, n1, n2);
          chk({n0, n1, n2} == 3'b000, "R8 read acks", {21'h0, n0, n1, n2}, 24'h0);
          chk(v == ew[k], "R8 read data", {16'h0, v}, {16'h0, ew[k]});
          chk(wiper_o == pk(ew) && nvm_o == pk(en), "R8 read no change", wiper_o, pk(ew));
          chk(sda_oe == 1'b0, "R9 release after stop", {23'h0, sda_oe}, 24'h0);
        end
      end
    end

    // R4 reserved selector
    for (int w = 0; w < 2; w++) begin
      wr({w[0], 7'b0000011}, 8'h5A, n0, n1, n2);
      chk(n0 == 1'b0 && n1 == 1'b1 && n2 == 1'b1, "R4 nack", {21'h0, n0, n1, n2}, 24'h3);
      chk(wiper_o == pk(ew) && nvm_o == pk(en), "R4 no change", wiper_o, pk(ew));
    end

    // R5 middle bits
    for (int b = 2; b < 7; b++) begin
      wr(8'h80 | 8'(1 << b) | 8'(b % 3), 8'hC3, n0, n1, n2);
      chk(n0 == 1'b0 && n1 == 1'b1 && n2 == 1'b1, "R5 nack", {21'h0, n0, n1, n2}, 24'h3);
      chk(wiper_o == pk(ew) && nvm_o == pk(en), "R5 no change", wiper_o, pk(ew));
    end

    // R2 every foreign address
    for (int a = 0; a < 128; a++) begin
      if (a != 7'h57) begin
        bstart();
        sbyte({a[6:0], a[0]}, n0);
        bstop();
        chk(n0 == 1'b1, "R2 foreign address nack", {23'h0, n0}, 24'h1);
      end
    end

    // R10 bytes after a nacked address are ignored
    bstart();
    sbyte(8'hA0, n0);
    sbyte(8'h81, n1);
    sbyte(8'h3C, n2);
    bstop();
    chk({n0, n1, n2} == 3'b111, "R10 ignored after nack", {21'h0, n0, n1, n2}, 24'h7);
    chk(wiper_o == pk(ew) && nvm_o == pk(en), "R10 no change", wiper_o, pk(ew));

    // R10 restart mid-write retargets
    bstart();
    sbyte(AW, n0);
    sbyte(8'h81, n1);
    bstart();
    sbyte(AW, n2);
    sbyte(8'h82, n3);
    sbyte(8'h96, n1);
    bstop();
    ew[2] = 8'h96; en[2] = 8'h96;
    chk(wiper_o == pk(ew) && nvm_o == pk(en), "R10 restart", wiper_o, pk(ew));

    // R9 sda released after the data ack
    bstart();
    sbyte(AW, n0);
    sbyte(8'h00, n1);
    sbyte(8'hE1, n2);
    chk(sda_oe == 1'b0, "R9 release after ack", {23'h0, sda_oe}, 24'h0);
    bstop();
    ew[0] = 8'hE1;
    chk(wiper_o == pk(ew) && nvm_o == pk(en), "R7 store flag clear", wiper_o, pk(ew));

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule